// File: doc/BRIEF.md
# Transmit Completion Indication Mailbox Writer

This block turns each transmit-completion event from a cell transmit engine into a 32-bit indication word and writes that word into one of two transmit mailboxes held in shared memory. An event is raised as soon as the engine has fetched all of a packet's data, not when the packet has left the line. The event carries an error flag, the virtual-channel number, whether the next packet descriptor is valid (the channel stays active), the start address of the descriptor just finished, and which of the two mailboxes receives it.

Each mailbox is a circular buffer. The block keeps a write pointer per mailbox, wraps it at a configurable depth, and tracks how many entries the host has not yet consumed. A write into a full mailbox is held back, with a busy indication, until the host acknowledges an entry. Nothing is dropped. Two event ports can fire in the same cycle, and a small ordered queue serialises them, port 0 first. Every mailbox write sets that mailbox's status bit. The host clears a status bit by writing a one to it. A per-mailbox mask gates the status bits onto a single interrupt line.

Top module: `txdone_mbox_writer`

## Requirements
- R1: The written word is: bit 31 = 1 when the event reports no error and 0 when it reports an error; bits 30:16 = VC number; bit 15 = 1 when the next descriptor is valid (channel stays active) and 0 when it is not (channel goes idle); bits 14:0 = low 15 bits of the descriptor start address.
- R2: An event accepted at clock edge N appears on the mailbox write port (`mb_we` high) after edge N+1, provided the target mailbox is not full and nothing is queued ahead of it.
- R3: A write to mailbox select 0 goes to byte address `MBA_BASE + 4*p`, and a write to select 1 goes to `MBB_BASE + 4*p`. Here p is that mailbox's own write pointer, which starts at 0 after reset and advances by one per write.
- R4: A mailbox write pointer returns to 0 after the write at slot `MB_DEPTH-1`.
- R5: When a mailbox holds `MB_DEPTH` unacknowledged entries, a write to it is held back and `mbox_busy` is high. One `mb_ack` pulse for that mailbox frees a slot, and the held indication is written next, unchanged and in order.
- R6: When both event ports are valid in the same cycle, the port 0 indication is written first and the port 1 indication in the following cycle.
- R7: A write to mailbox m sets `sts[m]` in the same cycle that `mb_we` is seen. The bit stays set until a host clear with `sts_clr[m]=1`. A set in the same cycle as a clear wins.
- R8: `irq` is high exactly when some `sts[m]` is 1 and `mask[m]` is 0. The mask is written with `mask_we`/`mask_in`.
- R9: After reset there is no write, `sts` is 0, the mask is 0, `irq` is 0 and `evt_ready` is 1.
- R10: `evt_ready` is low while fewer than two queue slots are free, and the source must hold events while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt0_valid | input | 1 | Completion event on port 0 |
| evt0_err | input | 1 | Port 0: 1 = packet had an error |
| evt0_vc | input | 15 | Port 0: VC number |
| evt0_next_ok | input | 1 | Port 0: next descriptor valid |
| evt0_desc | input | 32 | Port 0: descriptor start address |
| evt0_mbox | input | 1 | Port 0: mailbox select |
| evt1_valid | input | 1 | Completion event on port 1 |
| evt1_err | input | 1 | Port 1: 1 = packet had an error |
| evt1_vc | input | 15 | Port 1: VC number |
| evt1_next_ok | input | 1 | Port 1: next descriptor valid |
| evt1_desc | input | 32 | Port 1: descriptor start address |
| evt1_mbox | input | 1 | Port 1: mailbox select |
| evt_ready | output | 1 | Queue can take two events |
| mb_ack | input | 2 | Host consumed one entry of mailbox m |
| mb_we | output | 1 | Mailbox write strobe |
| mb_addr | output | MB_AW | Mailbox write byte address |
| mb_data | output | 32 | Indication word |
| mbox_busy | output | 1 | Head indication held by a full mailbox |
| sts_clr_we | input | 1 | Host status clear strobe |
| sts_clr | input | 2 | Write-one-to-clear bits |
| mask_we | input | 1 | Mask write strobe |
| mask_in | input | 2 | New mask value |
| sts | output | 2 | Per-mailbox status bits |
| irq | output | 1 | Interrupt |

## Verification
A table of eight events tests the word packing. The table covers all-ones and all-zero VC numbers and descriptor addresses whose bit 15 is set, so a truncation error or an off-by-one field boundary shows up. It also inverts the error sense in both directions and sets the active flag both ways. The table spreads five events over one mailbox and three over the other. That checks that the two pointers advance independently and that one of them wraps. A dual-port event in one cycle separates correct ordering from a swap or a lost second event. Filling a mailbox, then sending more events while it is full, separates holding from dropping. Checking `evt_ready` in that state shows whether backpressure is applied. The status and mask tests check that each mailbox's bit, its clear and its mask affect only that mailbox.

// File: rtl/txind_pkg.sv
package txind_pkg;

  localparam int VC_W   = 15;
  localparam int QP_W   = 15;
  localparam int ADDR_W = 32;
  localparam int IND_W  = 32;
  localparam int N_MBOX = 2;

  typedef struct packed {
    logic              err;
    logic [VC_W-1:0]   vc;
    logic              nxt_ok;
    logic [ADDR_W-1:0] daddr;
    logic              mbox;
  } txevt_t;

  // Pack one completion event into the indication word.
  function automatic logic [IND_W-1:0] pack_ind(input txevt_t e);
    logic [IND_W-1:0] w;
    w[31]    = ~e.err;
    w[30:16] = e.vc;
    w[15]    = e.nxt_ok;
    w[14:0]  = e.daddr[QP_W-1:0];
    return w;
  endfunction

endpackage

// File: rtl/txind_evq.sv
module txind_evq
  import txind_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push0,
  input  txevt_t ev0,
  input  logic   push1,
  input  txevt_t ev1,
  input  logic   pop,
  output txevt_t head,
  output logic   head_vld,
  output logic   room2
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  txevt_t        mem [DEPTH];
  logic [PW-1:0] rd_p, wr_p;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push0 && push1) begin
      mem[wr_p]       <= ev0;
      mem[step(wr_p)] <= ev1;
    end else if (push0 || push1) begin
      mem[wr_p] <= push0 ? ev0 : ev1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (push0 && push1)
        wr_p <= step(step(wr_p));
      else if (push0 || push1)
        wr_p <= step(wr_p);
      if (pop)
        rd_p <= step(rd_p);
      cnt <= cnt + CW'(push0) + CW'(push1) - CW'(pop);
    end
  end

  assign head     = mem[rd_p];
  assign head_vld = (cnt != '0);
  assign room2    = (cnt <= CW'(DEPTH - 2));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R5
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_vld);

endmodule

// File: rtl/txind_ring.sv
module txind_ring #(
  parameter int          DEPTH = 8,
  parameter int          AW    = 16,
  parameter int unsigned BASE  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          ack,
  output logic          full,
  output logic [AW-1:0] slot_addr
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);

  logic [PW-1:0] wptr;
  logic [FW-1:0] fill;
  logic          dec;

  // Byte address of a ring slot: base plus four bytes per word.
  function automatic logic [AW-1:0] slot_of(input logic [PW-1:0] p);
    return AW'(BASE + (32'(p) << 2));
  endfunction

  assign dec = ack && (fill != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      fill <= '0;
    end else begin
      if (wr)
        wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      fill <= fill + FW'(wr) - FW'(dec);
    end
  end

  assign full      = (fill == FW'(DEPTH));
  assign slot_addr = slot_of(wptr);

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wptr == PW'(DEPTH - 1)) |=> (wptr == '0));

  // R5
  no_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !full);

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));

endmodule

// File: rtl/txind_irq.sv
module txind_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic         clr_we,
  input  logic [N-1:0] clr_v,
  input  logic         mask_we,
  input  logic [N-1:0] mask_v,
  output logic [N-1:0] sts,
  output logic         irq
);

  logic [N-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_v;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        sts[i] <= 1'b0;
      else if (set_v[i])
        sts[i] <= 1'b1;
      else if (clr_we && clr_v[i])
        sts[i] <= 1'b0;
    end

    // R7
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[i] |=> sts[i]);

    // R7
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[i] && !(clr_we && clr_v[i])) |=> sts[i]);
  end

  assign irq = |(sts & ~mask_q);

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq);

endmodule

// File: rtl/txdone_mbox_writer.sv
module txdone_mbox_writer
  import txind_pkg::*;
#(
  parameter int          Q_DEPTH  = 4,
  parameter int          MB_DEPTH = 8,
  parameter int          MB_AW    = 16,
  parameter int unsigned MBA_BASE = 32'h0200,
  parameter int unsigned MBB_BASE = 32'h0300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt0_valid,
  input  logic             evt0_err,
  input  logic [14:0]      evt0_vc,
  input  logic             evt0_next_ok,
  input  logic [31:0]      evt0_desc,
  input  logic             evt0_mbox,
  input  logic             evt1_valid,
  input  logic             evt1_err,
  input  logic [14:0]      evt1_vc,
  input  logic             evt1_next_ok,
  input  logic [31:0]      evt1_desc,
  input  logic             evt1_mbox,
  output logic             evt_ready,
  input  logic [1:0]       mb_ack,
  output logic             mb_we,
  output logic [MB_AW-1:0] mb_addr,
  output logic [31:0]      mb_data,
  output logic             mbox_busy,
  input  logic             sts_clr_we,
  input  logic [1:0]       sts_clr,
  input  logic             mask_we,
  input  logic [1:0]       mask_in,
  output logic [1:0]       sts,
  output logic             irq
);

  localparam int unsigned BASES [N_MBOX] = '{MBA_BASE, MBB_BASE};

  txevt_t            ev0, ev1, q_head;
  logic              push0, push1, q_vld, q_room2;
  logic              issue, blocked;
  logic [N_MBOX-1:0] mb_full, mb_wr;
  logic [MB_AW-1:0]  slot [N_MBOX];

  assign ev0 = '{err: evt0_err, vc: evt0_vc, nxt_ok: evt0_next_ok,
                 daddr: evt0_desc, mbox: evt0_mbox};
  assign ev1 = '{err: evt1_err, vc: evt1_vc, nxt_ok: evt1_next_ok,
                 daddr: evt1_desc, mbox: evt1_mbox};

  assign evt_ready = q_room2;
  assign push0     = evt0_valid && q_room2;
  assign push1     = evt1_valid && q_room2;

  txind_evq #(.DEPTH(Q_DEPTH)) u_evq (
    .clk(clk), .rst_n(rst_n),
    .push0(push0), .ev0(ev0), .push1(push1), .ev1(ev1),
    .pop(issue), .head(q_head), .head_vld(q_vld), .room2(q_room2)
  );

  assign blocked   = mb_full[q_head.mbox];
  assign issue     = q_vld && !blocked;
  assign mbox_busy = q_vld && blocked;

  for (genvar m = 0; m < N_MBOX; m++) begin : g_ring
    assign mb_wr[m] = issue && (q_head.mbox == 1'(m));
    txind_ring #(.DEPTH(MB_DEPTH), .AW(MB_AW), .BASE(BASES[m])) u_ring (
      .clk(clk), .rst_n(rst_n), .wr(mb_wr[m]), .ack(mb_ack[m]),
      .full(mb_full[m]), .slot_addr(slot[m])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mb_we   <= 1'b0;
      mb_addr <= '0;
      mb_data <= '0;
    end else begin
      mb_we <= issue;
      if (issue) begin
        mb_addr <= slot[q_head.mbox];
        mb_data <= pack_ind(q_head);
      end
    end
  end

  txind_irq #(.N(N_MBOX)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_v(mb_wr),
    .clr_we(sts_clr_we), .clr_v(sts_clr),
    .mask_we(mask_we), .mask_v(mask_in),
    .sts(sts), .irq(irq)
  );

  // R2
  accept_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt0_valid && evt_ready) |=> q_vld);

  // R5
  busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_busy |=> !$past(issue) || !mb_we);

  // R6
  dual_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mb_wr));

endmodule

// File: tb/txdone_mbox_writer_tb_top.sv
module txdone_mbox_writer_tb_top;
  import txind_pkg::*;

  localparam int MBD = 4;
  localparam logic [15:0] BASE_A = 16'h0200;
  localparam logic [15:0] BASE_B = 16'h0300;

  // {err, vc[14:0], next_ok, desc[31:0], mbox}
  localparam logic [49:0] VEC [8] = '{
    {1'b0, 15'h0011, 1'b1, 32'h0000_1A40, 1'b0},
    {1'b1, 15'h7FFF, 1'b0, 32'hFFFF_FFFC, 1'b1},
    {1'b0, 15'h0000, 1'b0, 32'h8000_0000, 1'b0},
    {1'b1, 15'h4A5A, 1'b1, 32'h0000_7FFF, 1'b0},
    {1'b0, 15'h2222, 1'b1, 32'h1234_5678, 1'b1},
    {1'b1, 15'h0001, 1'b1, 32'h0000_8001, 1'b0},
    {1'b0, 15'h3C3C, 1'b0, 32'h0000_0004, 1'b0},
    {1'b1, 15'h5555, 1'b0, 32'hABCD_EF00, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt0_valid = 0, evt0_err = 0, evt0_next_ok = 0, evt0_mbox = 0;
  logic evt1_valid = 0, evt1_err = 0, evt1_next_ok = 0, evt1_mbox = 0;
  logic [14:0] evt0_vc = '0, evt1_vc = '0;
  logic [31:0] evt0_desc = '0, evt1_desc = '0;
  logic [1:0]  mb_ack = '0, sts_clr = '0, mask_in = '0;
  logic sts_clr_we = 0, mask_we = 0;
  logic evt_ready, mb_we, mbox_busy, irq;
  logic [15:0] mb_addr;
  logic [31:0] mb_data;
  logic [1:0]  sts;

  int n_chk = 0, n_fail = 0;
  int ptr [2] = '{0, 0};
  bit done = 0;

  always #2.5 clk = ~clk;

  txdone_mbox_writer #(.Q_DEPTH(4), .MB_DEPTH(MBD), .MB_AW(16),
                       .MBA_BASE(32'h0200), .MBB_BASE(32'h0300)) dut_i (.*);

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [49:0] v);
    logic [31:0] w = '0;
    w = w | ({31'b0, !v[49]} << 31);
    w = w | (32'(v[48:34]) << 16);
    w = w | (32'(v[33]) << 15);
    w = w | (v[32:1] & 32'h0000_7FFF);
    return w;
  endfunction

  // Expected address for the next write to mailbox m; advances the model.
  function automatic logic [15:0] next_addr(input bit m);
    logic [15:0] a = (m ? BASE_B : BASE_A) + 16'(ptr[m] * 4);
    ptr[m] = (ptr[m] + 1) % MBD;
    return a;
  endfunction

  // Called at a negedge; returns one negedge later (one posedge taken).
  task automatic send(input bit v0, input logic [49:0] e0,
                      input bit v1, input logic [49:0] e1);
    evt0_valid = v0; {evt0_err, evt0_vc, evt0_next_ok, evt0_desc, evt0_mbox} = e0;
    evt1_valid = v1; {evt1_err, evt1_vc, evt1_next_ok, evt1_desc, evt1_mbox} = e1;
    @(negedge clk);
    evt0_valid = 0;
    evt1_valid = 0;
  endtask

  task automatic ack(input logic [1:0] m);
    mb_ack = m;
    @(negedge clk);
    mb_ack = '0;
  endtask

  task automatic expect_write(input logic [49:0] v, input string req);
    logic [15:0] ea;
    ea = next_addr(v[0]);
    chk(mb_we === 1'b1, req, 64'(mb_we), 64'd1);
    chk(mb_data === word_of(v), req, 64'(mb_data), 64'(word_of(v)));
    chk(mb_addr === ea, req, 64'(mb_addr), 64'(ea));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [49:0] ev;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk(mb_we === 1'b0, "R9 we", 64'(mb_we), 0);
    chk(sts === 2'b00, "R9 sts", 64'(sts), 0);
    chk(irq === 1'b0, "R9 irq", 64'(irq), 0);
    chk(evt_ready === 1'b1, "R9 ready", 64'(evt_ready), 1);

    // R1 R2 R3 R4: table walk, acked after each write
    for (int i = 0; i < 8; i++) begin
      send(1, VEC[i], 0, '0);
      chk(mb_we === 1'b0, "R2 not early", 64'(mb_we), 0);
      @(negedge clk);
      expect_write(VEC[i], (i == 6) ? "R4 wrap" : "R1/R3 word");
      ack(VEC[i][0] ? 2'b10 : 2'b01);
    end

    // R7 R8 status and mask
    chk(sts === 2'b11, "R7 set", 64'(sts), 3);
    chk(irq === 1'b1, "R8 irq", 64'(irq), 1);
    mask_we = 1; mask_in = 2'b01; @(negedge clk); mask_we = 0;
    chk(irq === 1'b1, "R8 part mask", 64'(irq), 1);
    mask_we = 1; mask_in = 2'b11; @(negedge clk); mask_we = 0;
    chk(irq === 1'b0, "R8 full mask", 64'(irq), 0);
    chk(sts === 2'b11, "R7 held", 64'(sts), 3);
    sts_clr_we = 1; sts_clr = 2'b01; @(negedge clk); sts_clr_we = 0;
    chk(sts === 2'b10, "R7 w1c", 64'(sts), 2);
    sts_clr_we = 1; sts_clr = 2'b11;
    mask_we = 1; mask_in = 2'b00; @(negedge clk);
    sts_clr_we = 0; mask_we = 0;
    chk(irq === 1'b0, "R8 cleared", 64'(irq), 0);

    // R6 dual event, port 0 first
    send(1, {1'b0, 15'h0A0A, 1'b1, 32'h0000_0100, 1'b0},
         1, {1'b1, 15'h0B0B, 1'b0, 32'h0000_0200, 1'b1});
    @(negedge clk);
    expect_write({1'b0, 15'h0A0A, 1'b1, 32'h0000_0100, 1'b0}, "R6 first");
    @(negedge clk);
    expect_write({1'b1, 15'h0B0B, 1'b0, 32'h0000_0200, 1'b1}, "R6 second");
    ack(2'b11);

    // R5 fill mailbox B
    for (int i = 0; i < MBD; i++) begin
      ev = {1'b0, 15'(16'h100 + i), 1'b1, 32'(i * 16), 1'b1};
      send(1, ev, 0, '0);
      @(negedge clk);
      expect_write(ev, "R5 fill");
    end
    send(1, {1'b1, 15'h0C01, 1'b1, 32'h0000_0C01, 1'b1},
         1, {1'b0, 15'h0C02, 1'b0, 32'h0000_0C02, 1'b1});
    @(negedge clk);
    chk(mb_we === 1'b0, "R5 held", 64'(mb_we), 0);
    chk(mbox_busy === 1'b1, "R5 busy", 64'(mbox_busy), 1);
    chk(evt_ready === 1'b1, "R10 two free", 64'(evt_ready), 1);
    send(1, {1'b1, 15'h0C03, 1'b0, 32'h0000_FC03, 1'b1}, 0, '0);
    chk(evt_ready === 1'b0, "R10 not ready", 64'(evt_ready), 0);
    chk(mb_we === 1'b0, "R5 still held", 64'(mb_we), 0);
    for (int k = 0; k < 3; k++) begin
      ack(2'b10);
      @(negedge clk);
      case (k)
        0: expect_write({1'b1, 15'h0C01, 1'b1, 32'h0000_0C01, 1'b1}, "R5 resume");
        1: expect_write({1'b0, 15'h0C02, 1'b0, 32'h0000_0C02, 1'b1}, "R5 order");
        default: expect_write({1'b1, 15'h0C03, 1'b0, 32'h0000_FC03, 1'b1}, "R5 order");
      endcase
    end
    chk(evt_ready === 1'b1, "R10 drained", 64'(evt_ready), 1);
    chk(mbox_busy === 1'b0, "R5 idle", 64'(mbox_busy), 0);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule